// File: doc/BRIEF.md
# Three-Level Ten-Segment Gate Sequencer

This block turns one switching period's worth of precomputed dwell times into gate commands for a three-phase, three-level converter. It takes three dwell counts: one for the zero state, one for the short state in which a single phase sits apart from the other two, and one for the short state in which two phases sit apart from the third. A one-cycle start pulse latches them. The block then plays a mirrored ten-segment pattern in which every state is split into equal-sized pieces, so the total time spent in each state adds up to its dwell count.

Each state is first built on three canonical phase roles. The roles are then rotated onto the physical phases according to the area index, so one pattern serves all six areas. Every phase drives a one-hot group of three gate enables: positive, zero and negative. That makes nine gate outputs in all. Two selects pick the redundant forms of the short states and of the zero state, which lets the controller steer the neutral point. Dwell computation and dead-time insertion are done elsewhere.

Top module: `tl_seq_gates`

## Requirements
- R1: While reset is asserted, and after it is released with no start, every phase drives its zero gate. The gate word is 9'b010_010_010: phase a is bits [2:0], phase b is bits [5:3] and phase c is bits [8:6]. Within each phase, bit 0 is positive, bit 1 is zero and bit 2 is negative.
- R2: In every cycle, each phase's three gate bits are one-hot.
- R3: After a start, the states are played in the order D, S, Z, S, D, D, S, Z, S, D. Here D is the two-apart short state, S is the single-apart short state and Z is the zero state. The first segment appears on the gates in the cycle that follows the clock edge that samples start.
- R4: Number the D segments 0 to 3 in play order, and do the same for the S segments. Segment k of D lasts floor((dwell_double+k)/4) cycles and segment k of S lasts floor((dwell_single+k)/4) cycles. The two Z segments last floor((dwell_zero+j)/2) cycles, for j = 0 and 1. The whole period therefore lasts exactly dwell_zero+dwell_single+dwell_double cycles.
- R5: A segment of length zero never appears on the gates, not even for a single cycle.
- R6: The roles (A, B, C) are written as levels, with H for positive, Z for zero and L for negative. short_sel picks the forms of the short states:
  - 0: upper forms, with S = HZZ and D = HHZ.
  - 1: lower forms, with S = ZLL and D = ZZL.
  - 2: upper forms in the first five segments and lower forms in the last five.
  - 3: lower forms in the first five segments and upper forms in the last five.
- R7: zero_sel picks the form of the zero state: 1 is HHH, 2 is LLL, and 0 or 3 is ZZZ.
- R8: Let r = area mod 3. Physical phase p (a=0, b=1, c=2) takes role (p−r) mod 3, where A=0, B=1 and C=2. For example, area 1 drives phase a with role C and phase b with role A. Area values 6 and 7 follow the same rule.
- R9: When a period ends with no new start, the gates move to the latched zero form and hold there. A start in which all three dwells are zero goes straight to that idle zero form.
- R10: A start always begins a new period from segment 0, using the inputs sampled at that edge. This holds even in the middle of a period, and even on the edge where the old period ends, in which case no idle cycle appears in between. Changes to the inputs without a start have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Period start pulse; latches all other inputs |
| dwell_zero | input | TW | Zero-state dwell in cycles |
| dwell_single | input | TW | Single-apart short-state dwell in cycles |
| dwell_double | input | TW | Two-apart short-state dwell in cycles |
| area | input | 3 | Area index; taken modulo 3 for the phase rotation |
| short_sel | input | 2 | Redundant short-state form select |
| zero_sel | input | 2 | Redundant zero-state form select |
| gate | output | 9 | One-hot gate groups for phases a, b and c |

## Verification
A start pulse can arrive on the same edge where the last segment of the running period expires, or where the sequencer is part-way through a segment. In either case, the restart has to win over both the move to idle and the normal segment step. The bench provokes the first case by raising start on exactly the cycle that shows the old period's last state. It provokes the second by restarting five cycles into a period. It then compares every following cycle against the new period's expected pattern, starting from its first segment, with no idle zero cycle allowed. A second coincidence is a run of zero-length segments at a boundary, which has to be skipped in that same step. Dwell sets that give several empty segments in a row exercise this case.

// File: rtl/tl_seq_gates.sv
module tl_seq_gates #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] dwell_zero,
  input  logic [TW-1:0] dwell_single,
  input  logic [TW-1:0] dwell_double,
  input  logic [2:0]    area,
  input  logic [1:0]    short_sel,
  input  logic [1:0]    zero_sel,
  output logic [8:0]    gate
);
  localparam logic [2:0] LP = 3'b001;
  localparam logic [2:0] LZ = 3'b010;
  localparam logic [2:0] LN = 3'b100;
  localparam logic [3:0] NONE = 4'd10;

  logic          act;
  logic [3:0]    seg;
  logic [TW-1:0] rem;
  logic [TW-1:0] lz, ls, ld;
  logic [1:0]    lrot, lss, lzs;

  logic [TW-1:0] uz, us, ud;
  logic [1:0]    urot, uss, uzs;
  logic [3:0]    from, nxt;
  logic          advance;

  function automatic logic [1:0] kind_of(input logic [3:0] i);
    case (i)
      4'd2, 4'd7:              return 2'd0;
      4'd1, 4'd3, 4'd6, 4'd8:  return 2'd1;
      default:                 return 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] occ_of(input logic [3:0] i);
    case (i)
      4'd3, 4'd4, 4'd7: return 2'd1;
      4'd5, 4'd6:       return 2'd2;
      4'd8, 4'd9:       return 2'd3;
      default:          return 2'd0;
    endcase
  endfunction

  function automatic logic [TW-1:0] seg_len(input logic [3:0] i,
      input logic [TW-1:0] z, input logic [TW-1:0] s, input logic [TW-1:0] d);
    logic [TW+1:0] o;
    logic [TW+1:0] sum;
    o = (TW+2)'(occ_of(i));
    case (kind_of(i))
      2'd0:    sum = ({2'b00, z} + o) >> 1;
      2'd1:    sum = ({2'b00, s} + o) >> 2;
      default: sum = ({2'b00, d} + o) >> 2;
    endcase
    return sum[TW-1:0];
  endfunction

  function automatic logic [3:0] next_seg(input logic [3:0] f,
      input logic [TW-1:0] z, input logic [TW-1:0] s, input logic [TW-1:0] d);
    logic [3:0] r;
    r = NONE;
    for (int i = 9; i >= 0; i--)
      if (4'(i) >= f && seg_len(4'(i), z, s, d) != '0) r = 4'(i);
    return r;
  endfunction

  function automatic logic [8:0] zero_vec(input logic [1:0] zs);
    case (zs)
      2'd1:    return {LP, LP, LP};
      2'd2:    return {LN, LN, LN};
      default: return {LZ, LZ, LZ};
    endcase
  endfunction

  function automatic logic [8:0] seg_vec(input logic [3:0] i, input logic [1:0] ss,
      input logic [1:0] zs, input logic [1:0] rot);
    logic up;
    logic [2:0] ra, rb, rc;
    up = (ss == 2'd0) || (ss == 2'd2 && i < 4'd5) || (ss == 2'd3 && i >= 4'd5);
    {rc, rb, ra} = zero_vec(zs);
    case (kind_of(i))
      2'd1:    {ra, rb, rc} = up ? {LP, LZ, LZ} : {LZ, LN, LN};
      2'd2:    {ra, rb, rc} = up ? {LP, LP, LZ} : {LZ, LZ, LN};
      default: ;
    endcase
    case (rot)
      2'd1:    return {rb, ra, rc};
      2'd2:    return {ra, rc, rb};
      default: return {rc, rb, ra};
    endcase
  endfunction

  assign uz   = start ? dwell_zero   : lz;
  assign us   = start ? dwell_single : ls;
  assign ud   = start ? dwell_double : ld;
  assign urot = start ? 2'(area % 3'd3) : lrot;
  assign uss  = start ? short_sel : lss;
  assign uzs  = start ? zero_sel  : lzs;
  assign from    = start ? 4'd0 : seg + 4'd1;
  assign nxt     = next_seg(from, uz, us, ud);
  assign advance = start || (act && rem <= TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      seg  <= '0;
      rem  <= '0;
      gate <= {LZ, LZ, LZ};
      lz   <= '0;
      ls   <= '0;
      ld   <= '0;
      lrot <= '0;
      lss  <= '0;
      lzs  <= '0;
    end else begin
      if (start) begin
        lz   <= dwell_zero;
        ls   <= dwell_single;
        ld   <= dwell_double;
        lrot <= urot;
        lss  <= short_sel;
        lzs  <= zero_sel;
      end
      if (advance) begin
        if (nxt == NONE) begin
          act  <= 1'b0;
          gate <= zero_vec(uzs);
        end else begin
          act  <= 1'b1;
          seg  <= nxt;
          rem  <= seg_len(nxt, uz, us, ud);
          gate <= seg_vec(nxt, uss, uzs, urot);
        end
      end else if (act) begin
        rem <= rem - TW'(1);
      end
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate[2:0]) == 1 && $countones(gate[5:3]) == 1 && $countones(gate[8:6]) == 1);

  a_r4_hold_in_segment: assert property (@(posedge clk) disable iff (!rst_n)
    (act && rem > TW'(1) && !start) |=> $stable(gate));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !start) |=> $stable(gate));

  a_r10_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (dwell_zero != '0 || dwell_single != '0 || dwell_double != '0)) |=> act);

  a_r5_no_empty_segment: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> rem != '0);
endmodule

// File: tb/test_tl_seq_gates.sv
`timescale 1ns/1ps
module test_tl_seq_gates;
  localparam int TW = 12;
  localparam int NE = 8;
  // entry: {dwell_zero, dwell_single, dwell_double, area, short_sel, zero_sel}
  localparam logic [42:0] TBL [NE] = '{
    {12'd4,  12'd4, 12'd4, 3'd0, 2'd0, 2'd0},
    {12'd6,  12'd5, 12'd7, 3'd1, 2'd1, 2'd1},
    {12'd3,  12'd9, 12'd2, 3'd2, 2'd2, 2'd2},
    {12'd0,  12'd8, 12'd8, 3'd3, 2'd3, 2'd0},
    {12'd10, 12'd0, 12'd3, 3'd4, 2'd0, 2'd1},
    {12'd1,  12'd1, 12'd1, 3'd5, 2'd1, 2'd2},
    {12'd5,  12'd6, 12'd0, 3'd6, 2'd2, 2'd0},
    {12'd2,  12'd3, 12'd4, 3'd7, 2'd3, 2'd1}
  };
  localparam int KIND [10] = '{2, 1, 0, 1, 2, 2, 1, 0, 1, 2};
  localparam int OCC  [10] = '{0, 0, 0, 1, 1, 2, 2, 1, 3, 3};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [TW-1:0] dz = '0, ds = '0, dd = '0;
  logic [2:0] area = '0;
  logic [1:0] ssel = '0, zsel = '0;
  logic [8:0] gate;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tl_seq_gates #(.TW(TW)) i_tl_seq_gates (
    .clk(clk), .rst_n(rst_n), .start(start), .dwell_zero(dz), .dwell_single(ds),
    .dwell_double(dd), .area(area), .short_sel(ssel), .zero_sel(zsel), .gate(gate));

  function automatic logic [2:0] lvl(input int v);
    return v > 0 ? 3'b001 : (v < 0 ? 3'b100 : 3'b010);
  endfunction

  function automatic logic [8:0] zform(input int zs);
    int v;
    v = zs == 1 ? 1 : (zs == 2 ? -1 : 0);
    return {lvl(v), lvl(v), lvl(v)};
  endfunction

  function automatic int total(input logic [42:0] e);
    return int'(e[42:31]) + int'(e[30:19]) + int'(e[18:7]);
  endfunction

  function automatic logic [8:0] expect_at(input logic [42:0] e, input int c);
    int t [3];
    int acc, len, r, ss, zs, k;
    int rl [3];
    int ph [3];
    bit up;
    t[0] = int'(e[42:31]); t[1] = int'(e[30:19]); t[2] = int'(e[18:7]);
    r = int'(e[6:4]) % 3; ss = int'(e[3:2]); zs = int'(e[1:0]);
    acc = 0;
    for (int s = 0; s < 10; s++) begin
      k = KIND[s];
      len = (k == 0) ? (t[0] + OCC[s]) / 2 : (t[k] + OCC[s]) / 4;
      if (c < acc + len) begin
        up = ss == 0 || (ss == 2 && s < 5) || (ss == 3 && s >= 5);
        if (k == 0) return zform(zs);
        if (k == 1) begin rl[0] = up ? 1 : 0; rl[1] = up ? 0 : -1; rl[2] = up ? 0 : -1; end
        else        begin rl[0] = up ? 1 : 0; rl[1] = up ? 1 : 0;  rl[2] = up ? 0 : -1; end
        for (int p = 0; p < 3; p++) ph[p] = rl[(p - r + 3) % 3];
        return {lvl(ph[2]), lvl(ph[1]), lvl(ph[0])};
      end
      acc += len;
    end
    return zform(zs);
  endfunction

  task automatic check(input string req, input logic [8:0] exp);
    checks++;
    if (gate !== exp) begin
      errors++;
      $display("FAIL %s: gate=%b expected=%b at %0t", req, gate, exp, $time);
    end
  endtask

  task automatic launch(input logic [42:0] e);
    {dz, ds, dd, area, ssel, zsel} = e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic play(input logic [42:0] e, input int from, input int n, input string req);
    for (int c = from; c < from + n; c++) begin
      check(req, expect_at(e, c));
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: gate=%b expected=completion", gate);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 reset", 9'b010_010_010);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 idle after reset", 9'b010_010_010);

    // R3 R4 R5 R6 R7 R8 R9: every table entry over a full period plus idle
    for (int i = 0; i < NE; i++) begin
      launch(TBL[i]);
      play(TBL[i], 0, total(TBL[i]) + 3, "R3/R4/R5/R6/R7/R8/R9 table");
    end

    // R9: all dwells zero goes straight to idle zero form
    launch({12'd0, 12'd0, 12'd0, 3'd1, 2'd0, 2'd2});
    check("R9 zero dwells", zform(2));
    @(negedge clk);
    check("R9 zero dwells hold", zform(2));

    // R10: inputs changed without start have no effect
    dz = 12'd7; area = 3'd2; zsel = 2'd1; ssel = 2'd3;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R10 ignore inputs", zform(2));
    end

    // R10: restart in mid-period
    launch(TBL[0]);
    play(TBL[0], 0, 5, "R10 before restart");
    launch(TBL[1]);
    play(TBL[1], 0, total(TBL[1]) + 2, "R10 mid restart");

    // R10: restart on the edge where the old period ends
    launch(TBL[2]);
    play(TBL[2], 0, total(TBL[2]) - 1, "R10 first period");
    check("R10 last segment", expect_at(TBL[2], total(TBL[2]) - 1));
    launch(TBL[7]);
    play(TBL[7], 0, total(TBL[7]) + 2, "R10 back-to-back");

    // R2: one-hot per phase over an idle stretch with LLL zero form
    launch({12'd2, 12'd4, 12'd4, 3'd0, 2'd1, 2'd2});
    for (int c = 0; c < 14; c++) begin
      checks++;
      if ($countones(gate[2:0]) != 1 || $countones(gate[5:3]) != 1 || $countones(gate[8:6]) != 1) begin
        errors++;
        $display("FAIL R2 one-hot: gate=%b expected=one bit per phase", gate);
      end
      @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule